// File: doc/BRIEF.md
# Strided Rectangle Copy Engine

This block turns a single rectangle-copy command into a series of row transfers. It hands those transfers one at a time to a downstream burst splitter. A command names one of three routes: internal memory to an external bank, an external bank to internal memory, or one external bank to another. It also carries a row length in bytes, a count of scanlines, and a start address, stride and stride enable for each of the source and the destination. Each row is one operation. On the bank-to-bank route, each row is two operations: a read into a fixed staging area, then a write of the same length out of it.

When a row finishes, the source address and the destination address each move forward by their own byte-granular stride, and only if that side's enable is set. With both strides disabled and one scanline, the result is a plain linear copy. With strides enabled, the same engine packs a screen window into contiguous memory, unpacks it back out, or restores part of a saved window.

On the bank side, an address wraps inside its bank under a per-side mask and never carries into the bank field. The engine refuses any command that would write to a read-only bank.

The splitter may hold an operation for as long as it likes, for example to serve higher-priority traffic. During that time the engine keeps every field of the operation unchanged. A one-cycle done pulse marks the end of the command.

Top module: `sscopy_engine`

## Requirements
- R1: After reset, `busy`, `done` and `op_valid` are all low.
- R2: With `cmd_mode` = 0 (internal to bank), each row is one write operation (`op_write`=1) with `op_bank_addr` = destination and `op_int_addr` = source. With `cmd_mode` = 1 (bank to internal), each row is one read operation (`op_write`=0) with `op_bank_addr` = source and `op_int_addr` = destination.
- R3: With `cmd_mode` = 2 (bank to bank), each row is a read of the source bank into `op_int_addr` = STAGE_BASE, followed by a write of the same length from STAGE_BASE to the destination bank.
- R4: Every operation carries `op_len` equal to the command's row byte count.
- R5: After a row's last operation completes, the source address advances by `cmd_src_off` only if `cmd_src_step` is 1, and the destination address advances by `cmd_dst_off` only if `cmd_dst_step` is 1. A side whose enable is 0 keeps its address.
- R6: With both enables 0 and a scanline count of 1, the command performs exactly one row (a linear copy) and then completes.
- R7: A scanline count of N yields exactly N rows before completion.
- R8: A bank-side address steps as (addr & ~mask) | ((addr + off) & mask). Bits outside the mask are kept.
- R9: An internal-side address steps by a plain full-width add, and its mask input has no effect.
- R10: A command whose destination is a bank (mode 0 or 2) while `cmd_dst_ro` = 1 is ignored: no operation, no busy, no done. Mode 3 is ignored too.
- R11: While `op_valid` is high and `op_done` has not arrived, `op_valid` and all operation fields stay unchanged, however long the wait.
- R12: `done` is high for exactly one cycle, in the cycle after the final operation's `op_done` is sampled. A scanline count of 0 raises `done` in the cycle after the command is accepted, with no operation issued.
- R13: A `cmd_valid` arriving while the engine is busy has no effect. This includes one that arrives in the same cycle as the final `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe; accepted only when idle |
| cmd_mode | input | 2 | Route: 0 int→bank, 1 bank→int, 2 bank→bank, 3 reserved |
| cmd_src_addr | input | ADDR_W | Source start address |
| cmd_dst_addr | input | ADDR_W | Destination start address |
| cmd_src_mask | input | ADDR_W | Wrap mask for a bank-side source |
| cmd_dst_mask | input | ADDR_W | Wrap mask for a bank-side destination |
| cmd_src_off | input | ADDR_W | Source stride per row |
| cmd_dst_off | input | ADDR_W | Destination stride per row |
| cmd_src_step | input | 1 | Enable for the source stride |
| cmd_dst_step | input | 1 | Enable for the destination stride |
| cmd_dst_ro | input | 1 | Destination bank is read-only |
| cmd_row_bytes | input | LEN_W | Bytes per row |
| cmd_lines | input | LINE_W | Scanline count |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| op_valid | output | 1 | Operation presented to the splitter |
| op_write | output | 1 | 1 = write into bank, 0 = read from bank |
| op_bank_addr | output | ADDR_W | External bank address of the operation |
| op_int_addr | output | ADDR_W | Internal (or staging) address of the operation |
| op_len | output | LEN_W | Operation length in bytes |
| op_done | input | 1 | Splitter reports the operation complete |

## Verification
Two things can land in the same clock edge: the completion of the final row, and a fresh command. The final row's completion advances both addresses, decrements the scanline counter and moves the engine toward done. The bench raises `cmd_valid` in the same cycle as the last `op_done` and requires a single done pulse, no further operation, and an idle engine afterwards. Stride and wrap also meet in one edge. A bank address near the top of its mask steps across the boundary while the internal side steps across the full address width, and each result is compared with its own formula.

// File: rtl/sscopy_pkg.sv
// Shared types for the strided copy engine.
// Assumes: route encoding is fixed by the command interface (0..3).
package sscopy_pkg;
    typedef enum logic [1:0] {
        XF_INT2BANK  = 2'd0,
        XF_BANK2INT  = 2'd1,
        XF_BANK2BANK = 2'd2,
        XF_RSVD      = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } eng_state_e;
endpackage

// File: rtl/sscopy_addr_step.sv
// Per-side address register with optional stride.
// On load it captures the start address, stride, enable, mask and whether
// the side lives in an external bank. On adv, if enabled, it adds the stride;
// bank-side sums are confined to the mask, internal-side sums use full width.
// Assumes: load and adv are never high together.
module sscopy_addr_step #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [ADDR_W-1:0] load_off,
    input  logic [ADDR_W-1:0] load_mask,
    input  logic              load_en,
    input  logic              load_bank,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q, off_q, mask_q;
    logic              en_q, bank_q;
    logic [ADDR_W-1:0] sum;

    // Raw stride sum, wrapped at full width.
    assign sum = addr_q + off_q;

    // Capture the command fields, then step once per completed row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            off_q  <= '0;
            mask_q <= '0;
            en_q   <= 1'b0;
            bank_q <= 1'b0;
        end else if (load) begin
            addr_q <= load_addr;
            off_q  <= load_off;
            mask_q <= load_mask;
            en_q   <= load_en;
            bank_q <= load_bank;
        end else if (adv && en_q) begin
            addr_q <= bank_q ? ((addr_q & ~mask_q) | (sum & mask_q)) : sum;
        end
    end

    assign addr = addr_q;

    // R8
    bank_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load && bank_q |=> (addr_q & ~mask_q) == $past(addr_q & ~mask_q));

    // R5
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load && !en_q |=> $stable(addr_q));
endmodule

// File: rtl/sscopy_row_ctr.sv
// Scanline counter: loaded with the row count, decremented per finished row.
// Assumes: dec is only asserted while rows remain.
module sscopy_row_ctr #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] load_count,
    input  logic              dec,
    output logic              last
);
    logic [LINE_W-1:0] cnt_q;

    // Hold the number of rows still to be moved.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (load)  cnt_q <= load_count;
        else if (dec)   cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == LINE_W'(1));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt_q != '0);
endmodule

// File: rtl/sscopy_engine.sv
// Strided rectangle copy engine (top).
// Accepts a copy command when idle, then issues one operation per row
// (two for bank-to-bank, through STAGE_BASE) to a burst splitter, holding
// each until op_done. Strides are applied at row end; done pulses once.
// Assumes: op_done is a single-cycle pulse given only while op_valid is high.
module sscopy_engine #(
    parameter int                ADDR_W     = 24,
    parameter int                LEN_W      = 16,
    parameter int                LINE_W     = 12,
    parameter logic [ADDR_W-1:0] STAGE_BASE = ADDR_W'(16'hF000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_mode,
    input  logic [ADDR_W-1:0] cmd_src_addr,
    input  logic [ADDR_W-1:0] cmd_dst_addr,
    input  logic [ADDR_W-1:0] cmd_src_mask,
    input  logic [ADDR_W-1:0] cmd_dst_mask,
    input  logic [ADDR_W-1:0] cmd_src_off,
    input  logic [ADDR_W-1:0] cmd_dst_off,
    input  logic              cmd_src_step,
    input  logic              cmd_dst_step,
    input  logic              cmd_dst_ro,
    input  logic [LEN_W-1:0]  cmd_row_bytes,
    input  logic [LINE_W-1:0] cmd_lines,
    output logic              busy,
    output logic              done,
    output logic              op_valid,
    output logic              op_write,
    output logic [ADDR_W-1:0] op_bank_addr,
    output logic [ADDR_W-1:0] op_int_addr,
    output logic [LEN_W-1:0]  op_len,
    input  logic              op_done
);
    import sscopy_pkg::*;

    xfer_mode_e        cmd_m, mode_q;
    eng_state_e        state_q, state_d;
    logic [LEN_W-1:0]  len_q;
    logic              src_bank, dst_bank, cmd_legal, accept, row_end, last_row;
    logic [ADDR_W-1:0] src_addr, dst_addr;

    // Decode which sides of the incoming command are bank-side.
    assign cmd_m     = xfer_mode_e'(cmd_mode);
    assign src_bank  = (cmd_m == XF_BANK2INT) || (cmd_m == XF_BANK2BANK);
    assign dst_bank  = (cmd_m == XF_INT2BANK) || (cmd_m == XF_BANK2BANK);
    assign cmd_legal = (cmd_m != XF_RSVD) && !(dst_bank && cmd_dst_ro);
    assign accept    = cmd_valid && (state_q == ST_IDLE) && cmd_legal;

    // A row ends on the completion of its final operation.
    assign row_end = op_done && ((state_q == ST_WRITE) ||
                                 (state_q == ST_READ && mode_q == XF_BANK2INT));

    sscopy_addr_step #(.ADDR_W(ADDR_W)) u_src (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .load_addr(cmd_src_addr), .load_off(cmd_src_off), .load_mask(cmd_src_mask),
        .load_en(cmd_src_step), .load_bank(src_bank), .adv(row_end), .addr(src_addr));

    sscopy_addr_step #(.ADDR_W(ADDR_W)) u_dst (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .load_addr(cmd_dst_addr), .load_off(cmd_dst_off), .load_mask(cmd_dst_mask),
        .load_en(cmd_dst_step), .load_bank(dst_bank), .adv(row_end), .addr(dst_addr));

    sscopy_row_ctr #(.LINE_W(LINE_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_count(cmd_lines),
        .dec(row_end), .last(last_row));

    // Sequence the read and write phases of each row.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (accept) begin
                    if (cmd_lines == '0)            state_d = ST_FINISH;
                    else if (cmd_m == XF_INT2BANK)  state_d = ST_WRITE;
                    else                            state_d = ST_READ;
                end
            ST_READ:
                if (op_done) begin
                    if (mode_q == XF_BANK2BANK)     state_d = ST_WRITE;
                    else if (last_row)              state_d = ST_FINISH;
                end
            ST_WRITE:
                if (op_done) begin
                    if (last_row)                   state_d = ST_FINISH;
                    else if (mode_q == XF_BANK2BANK) state_d = ST_READ;
                end
            ST_FINISH:                              state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    // State, route and row length registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= XF_INT2BANK;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                mode_q <= cmd_m;
                len_q  <= cmd_row_bytes;
            end
        end
    end

    // Present the current operation to the splitter.
    always_comb begin
        op_valid     = (state_q == ST_READ) || (state_q == ST_WRITE);
        op_write     = (state_q == ST_WRITE);
        op_bank_addr = (state_q == ST_READ) ? src_addr : dst_addr;
        op_len       = len_q;
        unique case (mode_q)
            XF_INT2BANK: op_int_addr = src_addr;
            XF_BANK2INT: op_int_addr = dst_addr;
            default:     op_int_addr = STAGE_BASE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_FINISH);

    // R11
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_done |=> op_valid && $stable(op_bank_addr) &&
        $stable(op_int_addr) && $stable(op_write) && $stable(op_len));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R10
    ro_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && cmd_dst_ro && (cmd_mode != 2'd1) |=> !busy);

    // R3
    stage_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done && !op_write && (mode_q == XF_BANK2BANK) |=>
        op_valid && op_write && op_len == $past(op_len));
endmodule

// File: tb/sscopy_engine_tb.sv
module sscopy_engine_tb;
    localparam int AW = 24;
    localparam int LW = 16;
    localparam int NW = 12;
    localparam logic [AW-1:0] STAGE = 24'h00F000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_mode = '0;
    logic [AW-1:0] cmd_src_addr = '0, cmd_dst_addr = '0, cmd_src_mask = '0, cmd_dst_mask = '0;
    logic [AW-1:0] cmd_src_off = '0, cmd_dst_off = '0;
    logic cmd_src_step = 1'b0, cmd_dst_step = 1'b0, cmd_dst_ro = 1'b0;
    logic [LW-1:0] cmd_row_bytes = '0;
    logic [NW-1:0] cmd_lines = '0;
    logic busy, done, op_valid, op_write, op_done = 1'b0;
    logic [AW-1:0] op_bank_addr, op_int_addr;
    logic [LW-1:0] op_len;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sscopy_engine #(.ADDR_W(AW), .LEN_W(LW), .LINE_W(NW), .STAGE_BASE(STAGE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_src_addr(cmd_src_addr), .cmd_dst_addr(cmd_dst_addr),
        .cmd_src_mask(cmd_src_mask), .cmd_dst_mask(cmd_dst_mask),
        .cmd_src_off(cmd_src_off), .cmd_dst_off(cmd_dst_off),
        .cmd_src_step(cmd_src_step), .cmd_dst_step(cmd_dst_step), .cmd_dst_ro(cmd_dst_ro),
        .cmd_row_bytes(cmd_row_bytes), .cmd_lines(cmd_lines),
        .busy(busy), .done(done), .op_valid(op_valid), .op_write(op_write),
        .op_bank_addr(op_bank_addr), .op_int_addr(op_int_addr), .op_len(op_len),
        .op_done(op_done));

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp below 100000", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [1:0] m, input logic [AW-1:0] sa, da, sm, dm, so, dof,
                            input logic ss, ds, ro, input logic [LW-1:0] len,
                            input logic [NW-1:0] lines);
        @(negedge clk);
        cmd_mode = m; cmd_src_addr = sa; cmd_dst_addr = da; cmd_src_mask = sm;
        cmd_dst_mask = dm; cmd_src_off = so; cmd_dst_off = dof; cmd_src_step = ss;
        cmd_dst_step = ds; cmd_dst_ro = ro; cmd_row_bytes = len; cmd_lines = lines;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Wait for an operation, check it, hold it for dly cycles, then complete it.
    task automatic expect_op(input string req, input logic wr, input logic [AW-1:0] ba, ia,
                             input logic [LW-1:0] len, input int dly);
        int waited = 0;
        bit held = 1'b1;
        while (!op_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        chk(op_valid == 1'b1, {req, " op_valid"}, op_valid, 1);
        chk(op_write == wr, {req, " op_write"}, op_write, wr);
        chk(op_bank_addr == ba, {req, " op_bank_addr"}, op_bank_addr, ba);
        chk(op_int_addr == ia, {req, " op_int_addr"}, op_int_addr, ia);
        chk(op_len == len, {req, " op_len R4"}, op_len, len);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            if (!op_valid || op_write != wr || op_bank_addr != ba || op_int_addr != ia ||
                op_len != len) held = 1'b0;
        end
        if (dly > 0) chk(held, {req, " R11 fields held while waiting"}, held, 1);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic expect_done(input string req);
        chk(done == 1'b1, {req, " R12 done after last op"}, done, 1);
        chk(op_valid == 1'b0, {req, " R7 no extra op"}, op_valid, 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {req, " R12 done one cycle"}, {done, busy}, 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0 && done == 1'b0 && op_valid == 1'b0, "R1 reset state",
            {busy, done, op_valid}, 0);
    endtask

    task automatic t_linear_int2bank();
        send_cmd(2'd0, 24'h000100, 24'h120010, 24'hFFFFFF, 24'h0FFFFF, 24'h40, 24'h40,
                 1'b0, 1'b0, 1'b0, 16'd64, 12'd1);
        expect_op("R2 R6 linear int2bank", 1'b1, 24'h120010, 24'h000100, 16'd64, 0);
        expect_done("R6 linear");
    endtask

    task automatic t_bank2int_src_stride();
        send_cmd(2'd1, 24'h100000, 24'h002000, 24'h0FFFFF, 24'hFFFFFF, 24'h200, 24'h80,
                 1'b1, 1'b0, 1'b0, 16'd16, 12'd3);
        expect_op("R2 R5 row0", 1'b0, 24'h100000, 24'h002000, 16'd16, 0);
        expect_op("R5 R11 row1", 1'b0, 24'h100200, 24'h002000, 16'd16, 3);
        expect_op("R5 R7 row2", 1'b0, 24'h100400, 24'h002000, 16'd16, 1);
        expect_done("R7 three rows");
    endtask

    task automatic t_bank2bank_both();
        send_cmd(2'd2, 24'h310000, 24'h450000, 24'h0FFFFF, 24'h0FFFFF, 24'h100, 24'h400,
                 1'b1, 1'b1, 1'b0, 16'd32, 12'd2);
        expect_op("R3 row0 read", 1'b0, 24'h310000, STAGE, 16'd32, 0);
        expect_op("R3 row0 write", 1'b1, 24'h450000, STAGE, 16'd32, 2);
        expect_op("R3 R5 row1 read", 1'b0, 24'h310100, STAGE, 16'd32, 0);
        expect_op("R3 R5 row1 write", 1'b1, 24'h450400, STAGE, 16'd32, 0);
        expect_done("R3 bank2bank");
    endtask

    task automatic t_wrap();
        send_cmd(2'd0, 24'hFFFFF0, 24'h2FFFF0, 24'h0000FF, 24'h0FFFFF, 24'h20, 24'h20,
                 1'b1, 1'b1, 1'b0, 16'd8, 12'd2);
        expect_op("R8 R9 row0", 1'b1, 24'h2FFFF0, 24'hFFFFF0, 16'd8, 0);
        expect_op("R8 R9 row1 wrap", 1'b1, 24'h200010, 24'h000010, 16'd8, 0);
        expect_done("R8 wrap");
    endtask

    task automatic t_ignored();
        send_cmd(2'd0, 24'h0, 24'h600000, 24'hFFFFFF, 24'h0FFFFF, 24'h0, 24'h0,
                 1'b0, 1'b0, 1'b1, 16'd4, 12'd1);
        repeat (3) @(negedge clk);
        chk(!busy && !op_valid && !done, "R10 read-only dest ignored", {busy, op_valid, done}, 0);
        send_cmd(2'd2, 24'h100000, 24'h600000, 24'h0FFFFF, 24'h0FFFFF, 24'h0, 24'h0,
                 1'b0, 1'b0, 1'b1, 16'd4, 12'd1);
        repeat (3) @(negedge clk);
        chk(!busy && !op_valid && !done, "R10 read-only bank2bank ignored",
            {busy, op_valid, done}, 0);
        send_cmd(2'd3, 24'h100000, 24'h600000, 24'h0FFFFF, 24'h0FFFFF, 24'h0, 24'h0,
                 1'b0, 1'b0, 1'b0, 16'd4, 12'd1);
        repeat (3) @(negedge clk);
        chk(!busy && !op_valid && !done, "R10 reserved mode ignored", {busy, op_valid, done}, 0);
    endtask

    task automatic t_zero_lines();
        send_cmd(2'd1, 24'h100000, 24'h002000, 24'h0FFFFF, 24'hFFFFFF, 24'h0, 24'h0,
                 1'b0, 1'b0, 1'b0, 16'd4, 12'd0);
        chk(done == 1'b1 && op_valid == 1'b0, "R12 zero lines done at once", {done, op_valid}, 2);
        @(negedge clk);
        chk(!done && !busy && !op_valid, "R12 zero lines idle after", {done, busy, op_valid}, 0);
    endtask

    task automatic t_busy_cmd();
        send_cmd(2'd1, 24'h500000, 24'h003000, 24'h0FFFFF, 24'hFFFFFF, 24'h0, 24'h0,
                 1'b0, 1'b0, 1'b0, 16'd8, 12'd1);
        // Second command while an operation is pending.
        cmd_mode = 2'd0; cmd_src_addr = 24'h000777; cmd_dst_addr = 24'h777777;
        cmd_lines = 12'd5; cmd_valid = 1'b1;
        @(negedge clk);
        chk(op_valid && !op_write && op_bank_addr == 24'h500000 && op_int_addr == 24'h003000,
            "R13 busy command ignored", op_bank_addr, 24'h500000);
        // Final completion and another command in the same cycle.
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0; cmd_valid = 1'b0;
        chk(done == 1'b1 && op_valid == 1'b0, "R13 R12 done with coincident command",
            {done, op_valid}, 2);
        @(negedge clk);
        chk(!busy && !op_valid && !done, "R13 coincident command not taken",
            {busy, op_valid, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear_int2bank();
        t_bank2int_src_stride();
        t_bank2bank_both();
        t_wrap();
        t_ignored();
        t_zero_lines();
        t_busy_cmd();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule